// File: doc/BRIEF.md
# I2C Read-Only Target with Software-Decided Address Acknowledge

This block is a 7-bit-address I2C target that serves read requests from a bus controller. It watches the filtered SCL and SDA lines for a Start, shifts in the address byte on rising SCL edges and compares it with an address that software programs. If the address matches and the direction bit asks for a read, the block either acknowledges on its own or, when the address-hold option is set, holds SCL low after the eighth falling edge. Software can then inspect the status, read the address, and choose the acknowledge value before it releases the clock.

After the acknowledged address, and after every data byte that the controller acknowledges, the block holds SCL low again and raises its interrupt. Software loads the next byte into the buffer register and releases the clock, and the byte goes out MSB first. A not-acknowledge from the controller ends the transfer: both lines are released and the block goes idle so the controller can issue a Stop. Both lines are open drain. Each is modelled as a drive-low enable and a sampled input, and each input passes through a two-flop synchronizer and a glitch filter.

Top module: `i2c_rd_target`

## Requirements
- R1: A Start condition (SDA falling while SCL is high) sets status bit 0 (start seen). It sets the interrupt flag (status bit 7, also the `irq` port) only when control bit 2 (start interrupt enable) is 1.
- R2: With control bit 1 (address hold) set, the eighth falling SCL edge of an address byte that equals the programmed address with R/W=1 clears control bit 0 (clock release), keeps SCL driven low and sets the interrupt flag. Status then shows R/W (bit 1) = 1, data-not-address (bit 2) = 0, acknowledge time (bit 3) = 1 and buffer full (bit 4) = 1.
- R3: The buffer register holds the received address byte {address, R/W}. A read of the buffer offset clears buffer full.
- R4: In the ninth clock of a matching address the block drives SDA to the value of control bit 3 (0 = ACK, drive low; 1 = NACK, release), and SCL is freed only once software writes clock release = 1. Without address hold the block drives ACK with no stretch. After a NACKed address the block drives neither line.
- R5: After an ACKed read address, the ninth falling edge clears clock release, holds SCL low, sets the interrupt flag and clears acknowledge time. Data-not-address reads 0.
- R6: A buffer write accepted while the block waits after an acknowledge sets buffer full. Once clock release is written to 1, the byte is shifted out MSB first, with SDA changing only while SCL is low.
- R7: The controller's acknowledge bit, sampled on the ninth rising SCL edge of a data byte, is stored in status bit 5 (0 = ACK). After an ACK the block holds SCL, sets the interrupt flag and sets data-not-address to 1, and the load and release sequence repeats.
- R8: When the controller answers NACK, the block releases SDA and SCL on the ninth falling edge and returns to idle.
- R9: A buffer write while buffer full is 1, or at any time other than the wait after an acknowledge, is ignored and sets status bit 6 (write collision).
- R10: A Stop condition (SDA rising while SCL is high) returns the block to idle, releases both lines and clears start seen.
- R11: A pulse on either line shorter than FILT_LEN system-clock cycles after synchronization is ignored.
- R12: An address byte that differs from the programmed address, or has R/W=0, is not acknowledged (SDA stays released in the ninth clock).
- R13: Register offsets: 0 control {3 ack value, 2 start interrupt enable, 1 address hold, 0 clock release}, 1 status, 2 buffer, 3 own address in bits 6:0. Writing 1 to status bit 7 or bit 6 clears that bit. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_oe | output | 1 | Drive SDA low when 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the offset |
| irq | output | 1 | Interrupt flag |

## Verification
A register write takes effect at the next rising edge. Read data follows the offset combinationally, so the bench drives strobes on the falling edge and samples `reg_rdata` shortly after. A line change reaches the protocol logic two synchronizer cycles plus FILT_LEN filter cycles plus one edge-detect cycle later, and any line or status result follows on the next edge, which is about seven cycles with the default filter. The bench controller holds every SCL phase for 40 cycles and inspects status or output enables no earlier than 20 cycles after the edge that causes them. Stretch checks release SCL and wait 60 cycles before they look at the line.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADR_W  = 7;
    localparam int unsigned CNT_W  = 4;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_BUF  = 2'd2;
    localparam logic [1:0] RA_OWN  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AHOLD,
        ST_AACK,
        ST_DHOLD,
        ST_DTX,
        ST_DACK,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] dbuf;
        logic [ADR_W-1:0]  own;
        logic              rel;
        logic              hold_en;
        logic              start_ie;
        logic              ack_val;
        logic              start_seen;
        logic              rw;
        logic              data_ind;
        logic              ack_time;
        logic              buf_full;
        logic              ack_stat;
        logic              wcol;
        logic              irq;
        logic              tx_rdy;
        logic              nack_addr;
        logic              scl_oe;
        logic              sda_oe;
    } eng_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int unsigned CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic          s1_d, s1_q, s2_d, s2_q, out_d, out_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        s1_d  = line_i;
        s2_d  = s1_q;
        out_d = out_q;
        cnt_d = cnt_q;
        if (s2_q == out_q) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_LAST) begin
            out_d = s2_q;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= 1'b1;
            s2_q  <= 1'b1;
            out_q <= 1'b1;
            cnt_q <= '0;
        end else begin
            s1_q  <= s1_d;
            s2_q  <= s2_d;
            out_q <= out_d;
            cnt_q <= cnt_d;
        end
    end

    assign line_o = out_q;

    AST_FILT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> ($past(s2_q) == out_q)); // R11

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_prev_d, scl_prev_q, sda_prev_d, sda_prev_q;

    always_comb begin
        scl_prev_d = scl_f;
        sda_prev_d = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_rise = scl_f & ~scl_prev_q;
    assign scl_fall = ~scl_f & scl_prev_q;
    assign start_ev = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
    assign stop_ev  = scl_f & scl_prev_q & ~sda_prev_q & sda_f;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              irq
);
    localparam logic [CNT_W-1:0] ADR_BITS = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(BYTE_W - 1);

    eng_t d, q;
    logic addr_hit;

    assign addr_hit = (q.sh[BYTE_W-1:1] == q.own) && q.sh[0];

    always_comb begin
        d = q;

        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: begin
                    d.rel      = reg_wdata[0];
                    d.hold_en  = reg_wdata[1];
                    d.start_ie = reg_wdata[2];
                    d.ack_val  = reg_wdata[3];
                end
                RA_STAT: begin
                    if (reg_wdata[6]) d.wcol = 1'b0;
                    if (reg_wdata[7]) d.irq  = 1'b0;
                end
                RA_BUF: begin
                    if (q.st == ST_DHOLD && !q.buf_full) begin
                        d.dbuf     = reg_wdata;
                        d.buf_full = 1'b1;
                        d.tx_rdy   = 1'b1;
                    end else begin
                        d.wcol = 1'b1;
                    end
                end
                default: d.own = reg_wdata[ADR_W-1:0];
            endcase
        end
        if (reg_rd && reg_addr == RA_BUF) begin
            d.buf_full = 1'b0;
        end

        case (q.st)
            ST_ADDR: begin
                if (scl_rise) begin
                    d.sh  = {q.sh[BYTE_W-2:0], sda_f};
                    d.cnt = q.cnt + CNT_W'(1);
                end else if (scl_fall && q.cnt == ADR_BITS) begin
                    if (addr_hit) begin
                        d.dbuf     = q.sh;
                        d.buf_full = 1'b1;
                        d.rw       = 1'b1;
                        d.data_ind = 1'b0;
                        d.ack_time = 1'b1;
                        if (q.hold_en) begin
                            d.st     = ST_AHOLD;
                            d.rel    = 1'b0;
                            d.irq    = 1'b1;
                            d.scl_oe = 1'b1;
                            d.sda_oe = ~d.ack_val;
                        end else begin
                            d.st        = ST_AACK;
                            d.nack_addr = 1'b0;
                            d.sda_oe    = 1'b1;
                        end
                    end else begin
                        d.st = ST_IGNORE;
                    end
                end
            end
            ST_AHOLD: begin
                d.scl_oe = 1'b1;
                d.sda_oe = ~d.ack_val;
                if (d.rel) begin
                    d.st        = ST_AACK;
                    d.scl_oe    = 1'b0;
                    d.nack_addr = d.ack_val;
                end
            end
            ST_AACK: begin
                if (scl_fall) begin
                    d.ack_time = 1'b0;
                    d.sda_oe   = 1'b0;
                    if (q.nack_addr) begin
                        d.st = ST_IGNORE;
                    end else begin
                        d.st     = ST_DHOLD;
                        d.rel    = 1'b0;
                        d.irq    = 1'b1;
                        d.scl_oe = 1'b1;
                        d.tx_rdy = 1'b0;
                    end
                end
            end
            ST_DHOLD: begin
                d.scl_oe = 1'b1;
                d.sda_oe = d.tx_rdy & ~d.dbuf[BYTE_W-1];
                if (d.rel && d.tx_rdy) begin
                    d.st       = ST_DTX;
                    d.sh       = d.dbuf;
                    d.cnt      = '0;
                    d.buf_full = 1'b0;
                    d.tx_rdy   = 1'b0;
                    d.scl_oe   = 1'b0;
                end
            end
            ST_DTX: begin
                if (scl_fall) begin
                    if (q.cnt == TX_LAST) begin
                        d.st     = ST_DACK;
                        d.sda_oe = 1'b0;
                    end else begin
                        d.sh     = {q.sh[BYTE_W-2:0], 1'b0};
                        d.cnt    = q.cnt + CNT_W'(1);
                        d.sda_oe = ~q.sh[BYTE_W-2];
                    end
                end
            end
            ST_DACK: begin
                if (scl_rise) begin
                    d.ack_stat = sda_f;
                end else if (scl_fall) begin
                    if (q.ack_stat) begin
                        d.st     = ST_IDLE;
                        d.scl_oe = 1'b0;
                        d.sda_oe = 1'b0;
                    end else begin
                        d.st       = ST_DHOLD;
                        d.rel      = 1'b0;
                        d.irq      = 1'b1;
                        d.scl_oe   = 1'b1;
                        d.data_ind = 1'b1;
                    end
                end
            end
            default: begin
                d.scl_oe = 1'b0;
                d.sda_oe = 1'b0;
            end
        endcase

        if (start_ev) begin
            d.st         = ST_ADDR;
            d.cnt        = '0;
            d.scl_oe     = 1'b0;
            d.sda_oe     = 1'b0;
            d.tx_rdy     = 1'b0;
            d.start_seen = 1'b1;
            if (q.start_ie) d.irq = 1'b1;
        end else if (stop_ev) begin
            d.st         = ST_IDLE;
            d.scl_oe     = 1'b0;
            d.sda_oe     = 1'b0;
            d.tx_rdy     = 1'b0;
            d.start_seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {4'b0, q.ack_val, q.start_ie, q.hold_en, q.rel};
            RA_STAT: reg_rdata = {q.irq, q.wcol, q.ack_stat, q.buf_full,
                                  q.ack_time, q.data_ind, q.rw, q.start_seen};
            RA_BUF:  reg_rdata = q.dbuf;
            default: reg_rdata = {1'b0, q.own};
        endcase
    end

    assign scl_oe = q.scl_oe;
    assign sda_oe = q.sda_oe;
    assign irq    = q.irq;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && q.st == ST_ADDR && q.cnt == ADR_BITS && addr_hit && q.hold_en)
        |=> (q.scl_oe && !q.rel && q.irq && q.st == ST_AHOLD)); // R2

    AST_POST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_AACK && scl_fall && !q.nack_addr)
        |=> (q.st == ST_DHOLD && q.scl_oe && !q.rel && !q.ack_time)); // R5

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((d.sda_oe != q.sda_oe) && !start_ev && !stop_ev) |-> !scl_f); // R6

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DACK && scl_fall && q.ack_stat)
        |=> (!q.scl_oe && !q.sda_oe && q.st == ST_IDLE)); // R8

    AST_WCOL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_BUF && q.buf_full && q.st != ST_ADDR)
        |=> (q.wcol && $stable(q.dbuf))); // R9

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!q.scl_oe && !q.sda_oe && !q.start_seen && q.st == ST_IDLE)); // R10

endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic scl_rise, scl_fall, start_ev, stop_ev;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    i2c_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_lines[0]),
        .sda_f    (filt_lines[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_tgt_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (filt_lines[0]),
        .sda_f     (filt_lines[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .irq       (irq)
    );

endmodule

// File: tb/sim_i2c_rd_target.sv
`timescale 1ns/100ps
module sim_i2c_rd_target;

    localparam int HP = 40;

    typedef struct packed {
        logic [6:0] own;
        logic [6:0] tgt;
        logic       rw;
        logic       hold;
        logic       ackv;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [1:0] nb;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{7'h3A, 7'h3A, 1'b1, 1'b1, 1'b0, 8'hA5, 8'h3C, 2'd2},
        '{7'h3A, 7'h3A, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 2'd0},
        '{7'h51, 7'h51, 1'b1, 1'b0, 1'b0, 8'h81, 8'h00, 2'd1},
        '{7'h51, 7'h50, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 2'd0},
        '{7'h3A, 7'h3A, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic reg_wr = 1'b0;
    logic reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic scl_oe, sda_oe, irq;
    logic scl_ln, sda_ln;
    int   n_tests = 0;
    int   n_fail  = 0;

    assign scl_ln = !(m_scl_low || scl_oe);
    assign sda_ln = !(m_sda_low || sda_oe);

    always #2.5 clk = ~clk;

    i2c_rd_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_high();
        int k = 0;
        while (scl_ln !== 1'b1 && k < 4000) begin
            @(posedge clk);
            k++;
        end
        if (k >= 4000) chk("R2 stretch never released", 0, 1);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b1; cyc(HP);
        m_scl_low = 1'b1; cyc(HP);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; cyc(HP);
        m_scl_low = 1'b0; wait_high(); cyc(HP);
        m_sda_low = 1'b0; cyc(HP);
    endtask

    task automatic send_bit(input logic b);
        m_sda_low = ~b; cyc(HP);
        m_scl_low = 1'b0; wait_high(); cyc(HP);
        m_scl_low = 1'b1; cyc(HP);
    endtask

    task automatic recv_bit(output logic b);
        m_sda_low = 1'b0; cyc(HP);
        m_scl_low = 1'b0; wait_high(); cyc(HP / 2);
        b = sda_ln; cyc(HP / 2);
        m_scl_low = 1'b1; cyc(HP);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [7:0] r;
        logic       b;
        logic       hit;
        logic [7:0] rx;
        logic [7:0] tx;
        logic       last;
        hit = (v.own == v.tgt) && v.rw;
        wr(2'd3, {1'b0, v.own});
        wr(2'd0, {6'b0, v.hold, 1'b0});
        wr(2'd1, 8'hC0);
        bus_start();
        rd(2'd1, r);
        chk("R1 start seen", r[0], 1);
        chk("R1 no irq without start enable", r[7], 0);
        for (int i = 7; i >= 1; i--) send_bit(v.tgt[i - 1]);
        send_bit(v.rw);
        if (!hit) begin
            recv_bit(b);
            chk("R12 no ack for foreign address or write", b, 1);
            chk("R12 lines released", {scl_oe, sda_oe}, 0);
            bus_stop();
            return;
        end
        if (v.hold) begin
            m_scl_low = 1'b0; cyc(60);
            chk("R2 SCL held after address", scl_ln, 0);
            rd(2'd0, r);
            chk("R2 clock release cleared", r[0], 0);
            rd(2'd1, r);
            chk("R2 status after address", r & 8'h9E, 8'h9A);
            rd(2'd2, r);
            chk("R3 address byte in buffer", r, {v.tgt, 1'b1});
            rd(2'd1, r);
            chk("R3 buffer full cleared by read", r[4], 0);
            wr(2'd1, 8'h80);
            wr(2'd0, {4'b0, v.ackv, 1'b0, 1'b1, 1'b1});
        end
        recv_bit(b);
        chk("R4 address acknowledge value", b, v.hold ? v.ackv : 1'b0);
        if (v.hold && v.ackv) begin
            cyc(20);
            chk("R4 lines released after NACKed address", {scl_oe, sda_oe}, 0);
            bus_stop();
            return;
        end
        if (!v.hold) begin
            rd(2'd2, r);
            chk("R3 address byte in buffer", r, {v.tgt, 1'b1});
        end
        for (int k = 0; k < int'(v.nb); k++) begin
            m_scl_low = 1'b0; cyc(60);
            chk(k == 0 ? "R5 SCL held after address ack" : "R7 SCL held after data ack", scl_ln, 0);
            rd(2'd1, r);
            chk("R5 irq and data flag", {r[7], r[3], r[2]}, {1'b1, 1'b0, (k > 0) ? 1'b1 : 1'b0});
            wr(2'd1, 8'h80);
            tx = (k == 0) ? v.b0 : v.b1;
            wr(2'd2, tx);
            rd(2'd1, r);
            chk("R6 buffer full after load", r[4], 1);
            if (idx == 0 && k == 0) begin
                wr(2'd2, 8'hFF);
                rd(2'd1, r);
                chk("R9 collision on full buffer", r[6], 1);
                wr(2'd1, 8'h40);
            end
            wr(2'd0, {6'b0, v.hold, 1'b1});
            rx = 8'h00;
            for (int i = 0; i < 8; i++) begin
                recv_bit(b);
                rx = {rx[6:0], b};
            end
            chk("R6 byte shifted MSB first", rx, tx);
            last = (k == int'(v.nb) - 1);
            send_bit(last);
            cyc(20);
            rd(2'd1, r);
            chk("R7 controller ack captured", r[5], last);
            if (last) chk("R8 lines released after NACK", {scl_oe, sda_oe}, 0);
        end
        bus_stop();
        rd(2'd1, r);
        chk("R10 stop clears start seen", r[0], 0);
    endtask

    initial begin
        cyc(150000);
        chk("watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        cyc(5);
        rst_n = 1'b1;
        cyc(5);

        // reset state (R13)
        rd(2'd0, r); chk("R13 control reset", r, 0);
        rd(2'd1, r); chk("R13 status reset", r, 0);
        chk("R13 lines released at reset", {scl_oe, sda_oe, irq}, 0);
        wr(2'd0, 8'h0E);
        rd(2'd0, r); chk("R13 control readback", r, 8'h0E);
        wr(2'd0, 8'h00);

        // table of transactions
        for (int i = 0; i < 5; i++) run_vec(VEC[i], i);

        // write collision outside the acknowledge wait (R9)
        wr(2'd1, 8'hC0);
        wr(2'd2, 8'h77);
        rd(2'd1, r);
        chk("R9 collision when idle", {r[6], r[4]}, 2'b10);
        wr(2'd1, 8'h40);

        // start interrupt enable (R1)
        wr(2'd0, 8'h04);
        bus_start();
        cyc(10);
        chk("R1 irq on start when enabled", irq, 1);
        bus_stop();
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h00);

        // stop in the middle of an address (R10)
        wr(2'd3, 8'h3A);
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        rd(2'd1, r);
        chk("R10 stop mid address clears start seen", r[0], 0);
        chk("R10 lines released after stop", {scl_oe, sda_oe}, 0);

        // one-cycle SDA glitch while SCL high is not a start (R11)
        @(negedge clk); m_sda_low = 1'b1;
        @(negedge clk); m_sda_low = 1'b0;
        cyc(20);
        rd(2'd1, r);
        chk("R11 glitch rejected", r[0], 0);

        // recovery after the aborted address: full transfer again
        run_vec(VEC[2], 2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule